// File: doc/BRIEF.md
# Sequential Extended Divider

This block is the divide engine beside a processor datapath. It covers three operations. The first divides a signed 16-bit value by a signed 16-bit value. The second divides an unsigned 32-bit value by an unsigned 16-bit value. The third divides a signed 32-bit value by a signed 16-bit value. The operands are the three 16-bit working registers, called D, X and Y here. The 32-bit dividend is made of Y (upper half) and D (lower half).

The decoder pulses `start` with an operation code and the current register contents. The block takes the sign out of both operands and runs a restoring shift-subtract loop over the magnitudes, one quotient bit per clock. It then puts the signs back. At the end it raises `done` for exactly one cycle. In that cycle it presents the new register values, a write enable for each register, and the four condition flags with their own update enables. A zero divisor skips the loop entirely.

Top module: `xdiv_unit`

## Requirements
- R1: Operation code `op_sel`: 2'b00 is unsigned 32/16 (EDIV), 2'b01 is signed 32/16 (EDIVS), and 2'b10 or 2'b11 is signed 16/16 (IDIVS). For IDIVS, D is sign-extended into the dividend. On completion with a non-zero divisor, `x_we` and `d_we` are high and `y_we` is low; `x_out` carries the low 16 quotient bits and `d_out` the remainder.
- R2: For EDIV, the dividend is {Y,D} taken unsigned and X is the unsigned divisor. On completion `y_we` and `d_we` are high and `x_we` is low; `y_out` carries the low 16 quotient bits and `d_out` the remainder.
- R3: For EDIVS, the dividend is {Y,D} taken as signed 32-bit and X is the signed divisor. The register targets are the same as in R2.
- R4: The quotient is truncated toward zero. The remainder carries the sign of the dividend, and its magnitude is below the divisor's magnitude.
- R5: A zero X divisor gives a `done` pulse one cycle after the accepted start. In that cycle `flag_c`=1 and `c_we`=1, while `x_we`, `y_we`, `d_we` and `nzv_we` are all 0. `busy` never rises.
- R6: With a non-zero divisor, `done` brings `flag_c`=0, `c_we`=1 and `nzv_we`=1. `flag_z` is 1 exactly when the full quotient is zero, and `flag_n` equals bit 15 of the quotient.
- R7: `flag_v` is 1 for EDIV when the quotient exceeds 65535. For EDIVS and IDIVS, `flag_v` is 1 when the quotient lies outside -32768..32767. This includes -32768 / -1 and -2^31 / -1.
- R8: With a non-zero divisor, `busy` is high for 32 cycles after the accepted start, and `done` is high on the 33rd. `done` lasts exactly one cycle.
- R9: `start` is ignored while `busy` or `done` is high. Operands presented then do not change the result under way.
- R10: After reset, and on every cycle without `done`, `busy`, `done` and all write and flag-update enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken when idle) |
| op_sel | input | 2 | Operation code, see R1 |
| d_in | input | 16 | D register value |
| x_in | input | 16 | X register value (divisor) |
| y_in | input | 16 | Y register value |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle completion strobe |
| x_out | output | 16 | New X value (quotient, IDIVS) |
| y_out | output | 16 | New Y value (quotient, EDIV/EDIVS) |
| d_out | output | 16 | New D value (remainder) |
| x_we | output | 1 | Write X |
| y_we | output | 1 | Write Y |
| d_we | output | 1 | Write D |
| flag_c | output | 1 | Carry flag value (divide by zero) |
| flag_z | output | 1 | Zero flag value |
| flag_n | output | 1 | Negative flag value |
| flag_v | output | 1 | Overflow flag value |
| c_we | output | 1 | Update carry flag |
| nzv_we | output | 1 | Update Z, N and V flags |

## Verification
Take the clock edge that accepts `start` as cycle 0. A zero-divisor result is due in cycle 1, and every other result is due in cycle 33, with `busy` high in cycles 1 through 32. The bench derives that completion cycle from its own model before each operation. At every falling edge after the start it compares `done` and `busy` with the expected cycle. It reads the registers and flags only in the predicted `done` cycle, and in the following cycle it confirms that `done` has dropped. One run pulses `start` with other operands in the middle of an operation, and its result must still match the first operands.

// File: rtl/xdiv_pkg.sv
package xdiv_pkg;

  typedef enum logic [1:0] {
    OP_EDIV    = 2'b00,
    OP_EDIVS   = 2'b01,
    OP_IDIVS   = 2'b10,
    OP_IDIVS_B = 2'b11
  } div_op_e;

  // 16-bit dividend form (D only, sign extended)
  function automatic logic op_short(div_op_e op);
    return op[1];
  endfunction

  function automatic logic op_signed(div_op_e op);
    return op[1] | op[0];
  endfunction

endpackage

// File: rtl/xdiv_prep.sv
module xdiv_prep
  import xdiv_pkg::*;
#(
  parameter int W = 16
) (
  input  div_op_e          op,
  input  logic [W-1:0]     d_in,
  input  logic [W-1:0]     x_in,
  input  logic [W-1:0]     y_in,
  output logic [2*W-1:0]   dvd_mag,
  output logic [W-1:0]     dvs_mag,
  output logic             q_neg,
  output logic             r_neg,
  output logic             dvs_zero
);
  localparam int DW = 2 * W;

  function automatic logic [DW-1:0] mag_wide(logic [DW-1:0] v, logic neg);
    return neg ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [W-1:0] mag_narrow(logic [W-1:0] v, logic neg);
    return neg ? (~v + 1'b1) : v;
  endfunction

  logic [DW-1:0] dividend;
  logic          dvd_neg;
  logic          dvs_neg;

  always_comb begin
    dividend = op_short(op) ? {{W{d_in[W-1]}}, d_in} : {y_in, d_in};
    dvd_neg  = op_signed(op) & dividend[DW-1];
    dvs_neg  = op_signed(op) & x_in[W-1];
    dvd_mag  = mag_wide(dividend, dvd_neg);
    dvs_mag  = mag_narrow(x_in, dvs_neg);
    q_neg    = dvd_neg ^ dvs_neg;
    r_neg    = dvd_neg;
    dvs_zero = (x_in == '0);
  end

endmodule

// File: rtl/xdiv_core.sv
module xdiv_core #(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [2*W-1:0]   dvd_mag,
  input  logic [W-1:0]     dvs_mag,
  output logic             busy,
  output logic             last_step,
  output logic [2*W-1:0]   q_mag,
  output logic [W-1:0]     r_mag
);
  localparam int DW = 2 * W;
  localparam int CW = $clog2(DW);

  // One restoring step: returns {quotient bit, new partial remainder}
  function automatic logic [W:0] trial(logic [W-1:0] rem, logic inbit,
                                       logic [W-1:0] dvs);
    logic [W:0]   sh;
    logic [W+1:0] diff;
    sh   = {rem, inbit};
    diff = {1'b0, sh} - {2'b00, dvs};
    if (!diff[W+1]) return {1'b1, diff[W-1:0]};
    return {1'b0, sh[W-1:0]};
  endfunction

  logic [DW-1:0] acc_q;   // dividend bits shift out, quotient bits shift in
  logic [W-1:0]  rem_q;
  logic [W-1:0]  dvs_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic [W:0]    step;

  assign step      = trial(rem_q, acc_q[DW-1], dvs_q);
  assign busy      = busy_q;
  assign last_step = busy_q && (cnt_q == '0);
  assign q_mag     = acc_q;
  assign r_mag     = rem_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load) begin
      acc_q  <= dvd_mag;
      rem_q  <= '0;
      dvs_q  <= dvs_mag;
      cnt_q  <= CW'(DW - 1);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      acc_q <= {acc_q[DW-2:0], step[W]};
      rem_q <= step[W-1:0];
      cnt_q <= cnt_q - CW'(1);
      if (cnt_q == '0) busy_q <= 1'b0;
    end
  end

  // R4: partial remainder always stays below the divisor magnitude
  a_r4_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rem_q < dvs_q));

  // R9: the loop is never reloaded mid-run
  a_r9_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !load);

  // R8: one iteration per clock
  a_r8_count_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/xdiv_finish.sv
module xdiv_finish
  import xdiv_pkg::*;
#(
  parameter int W = 16
) (
  input  div_op_e          op,
  input  logic [2*W-1:0]   q_mag,
  input  logic [W-1:0]     r_mag,
  input  logic             q_neg,
  input  logic             r_neg,
  output logic [W-1:0]     quo_reg,
  output logic [W-1:0]     rem_reg,
  output logic             flag_z,
  output logic             flag_n,
  output logic             flag_v
);
  localparam int DW = 2 * W;

  function automatic logic [DW:0] signed_quo(logic [DW-1:0] m, logic neg);
    logic [DW:0] e;
    e = {1'b0, m};
    return neg ? (~e + 1'b1) : e;
  endfunction

  // True when the top bits are a pure sign extension of bit W-1
  function automatic logic fits_w_signed(logic [DW:0] q);
    return (&q[DW:W-1]) | ~(|q[DW:W-1]);
  endfunction

  logic [DW:0] quo_s;

  always_comb begin
    quo_s   = signed_quo(q_mag, q_neg);
    quo_reg = quo_s[W-1:0];
    rem_reg = r_neg ? (~r_mag + 1'b1) : r_mag;
    flag_z  = (q_mag == '0);
    flag_n  = quo_s[W-1];
    flag_v  = op_signed(op) ? ~fits_w_signed(quo_s) : (|q_mag[DW-1:W]);
  end

endmodule

// File: rtl/xdiv_unit.sv
module xdiv_unit
  import xdiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op_sel,
  input  logic [W-1:0] d_in,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] x_out,
  output logic [W-1:0] y_out,
  output logic [W-1:0] d_out,
  output logic         x_we,
  output logic         y_we,
  output logic         d_we,
  output logic         flag_c,
  output logic         flag_z,
  output logic         flag_n,
  output logic         flag_v,
  output logic         c_we,
  output logic         nzv_we
);
  localparam int DW = 2 * W;

  div_op_e       op_now, op_q;
  logic [DW-1:0] dvd_mag, q_mag;
  logic [W-1:0]  dvs_mag, r_mag, quo_reg, rem_reg;
  logic          q_neg, r_neg, dvs_zero;
  logic          qneg_q, rneg_q, dz_q, fin_q;
  logic          core_busy, core_last;

  // named events for the assertions
  logic idle, accept, core_load;

  assign op_now    = div_op_e'(op_sel);
  assign idle      = !core_busy && !fin_q;
  assign accept    = start && idle;
  assign core_load = accept && !dvs_zero;

  xdiv_prep #(.W(W)) u_prep (
    .op(op_now), .d_in(d_in), .x_in(x_in), .y_in(y_in),
    .dvd_mag(dvd_mag), .dvs_mag(dvs_mag),
    .q_neg(q_neg), .r_neg(r_neg), .dvs_zero(dvs_zero)
  );

  xdiv_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .load(core_load),
    .dvd_mag(dvd_mag), .dvs_mag(dvs_mag),
    .busy(core_busy), .last_step(core_last),
    .q_mag(q_mag), .r_mag(r_mag)
  );

  xdiv_finish #(.W(W)) u_finish (
    .op(op_q), .q_mag(q_mag), .r_mag(r_mag),
    .q_neg(qneg_q), .r_neg(rneg_q),
    .quo_reg(quo_reg), .rem_reg(rem_reg),
    .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= OP_EDIV;
      qneg_q <= 1'b0;
      rneg_q <= 1'b0;
      dz_q   <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      fin_q <= (accept && dvs_zero) || core_last;
      if (accept) begin
        op_q   <= op_now;
        qneg_q <= q_neg;
        rneg_q <= r_neg;
        dz_q   <= dvs_zero;
      end
    end
  end

  assign busy   = core_busy;
  assign done   = fin_q;
  assign x_out  = quo_reg;
  assign y_out  = quo_reg;
  assign d_out  = rem_reg;
  assign flag_c = dz_q;
  assign c_we   = fin_q;
  assign nzv_we = fin_q && !dz_q;
  assign d_we   = fin_q && !dz_q;
  assign x_we   = fin_q && !dz_q && op_short(op_q);
  assign y_we   = fin_q && !dz_q && !op_short(op_q);

  // R5: zero divisor finishes on the very next cycle with carry set
  a_r5_zero_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dvs_zero) |=> (done && flag_c && !d_we && !nzv_we && !busy));

  // R8: completion strobe is a single cycle
  a_r8_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: an iteration run always ends in done
  a_r8_busy_to_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  // R10: nothing is written outside the done cycle
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !(x_we || y_we || d_we || c_we || nzv_we));

  // R1/R2: exactly one quotient register is written on success
  a_r1_one_quotient_target: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !flag_c) |-> ((x_we ^ y_we) && d_we));

endmodule

// File: tb/tb_xdiv_unit.sv
module tb_xdiv_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op_sel = 2'b00;
  logic [15:0] d_in = '0, x_in = '0, y_in = '0;
  logic        busy, done, x_we, y_we, d_we;
  logic        flag_c, flag_z, flag_n, flag_v, c_we, nzv_we;
  logic [15:0] x_out, y_out, d_out;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  xdiv_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
    .d_in(d_in), .x_in(x_in), .y_in(y_in),
    .busy(busy), .done(done), .x_out(x_out), .y_out(y_out), .d_out(d_out),
    .x_we(x_we), .y_we(y_we), .d_we(d_we),
    .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v),
    .c_we(c_we), .nzv_we(nzv_we)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural model on 64-bit integers
  function automatic void model(input logic [1:0] op, input logic [15:0] d, x, y,
                                output bit dz, output logic [15:0] qr, rr,
                                output bit z, n, v);
    longint a, b, q, r;
    if (op[1]) begin
      a = longint'($signed(d));
      b = longint'($signed(x));
    end else if (op[0]) begin
      a = longint'($signed({y, d}));
      b = longint'($signed(x));
    end else begin
      a = {32'd0, y, d};
      b = {48'd0, x};
    end
    dz = (b == 0);
    q = 0; r = 0;
    if (!dz) begin
      q = a / b;
      r = a % b;
    end
    qr = q[15:0];
    rr = r[15:0];
    z  = (q == 0);
    n  = q[15];
    v  = (op == 2'b00) ? (q > 65535) : (q > 32767 || q < -32768);
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [15:0] d, x, y, input bit poke);
    bit dz, z, n, v;
    logic [15:0] qr, rr;
    int lat;
    model(op, d, x, y, dz, qr, rr, z, n, v);
    lat = dz ? 1 : 33;
    @(negedge clk);
    op_sel = op; d_in = d; x_in = x; y_in = y; start = 1'b1;
    for (int i = 1; i <= lat; i++) begin
      @(negedge clk);
      if (poke && i == 4) begin
        start = 1'b1; d_in = ~d; x_in = x + 16'd3; y_in = ~y; op_sel = ~op;
      end else start = 1'b0;
      chk(done == (i == lat), "R8 done timing", done, i == lat);
      chk(busy == (!dz && i < lat), dz ? "R5 busy stays low" : "R8 busy window",
          busy, !dz && i < lat);
      if (i == lat) begin
        chk(flag_c == dz, "R5/R6 carry", flag_c, dz);
        chk(c_we == 1'b1, "R6 carry update", c_we, 1);
        chk(nzv_we == !dz, "R5/R6 znv update", nzv_we, !dz);
        if (dz) begin
          chk(!x_we && !y_we && !d_we, "R5 no register write", {x_we, y_we, d_we}, 0);
        end else begin
          chk(d_we && d_out == rr, "R4 remainder", d_out, rr);
          if (op[1]) begin
            chk(x_we && !y_we && x_out == qr, "R1 idivs quotient", x_out, qr);
          end else begin
            chk(y_we && !x_we && y_out == qr, op[0] ? "R3 edivs quotient" : "R2 ediv quotient",
                y_out, qr);
          end
          chk(flag_z == z && flag_n == n, "R6 Z/N flags", {flag_z, flag_n}, {z, n});
          chk(flag_v == v, "R7 overflow flag", flag_v, v);
        end
      end
    end
    @(negedge clk);
    start = 1'b0;
    chk(!done && !c_we && !x_we && !y_we && !d_we, "R10 quiet after done", done, 0);
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R10 reset idle", {busy, done}, 0);
    chk(!x_we && !y_we && !d_we && !c_we && !nzv_we, "R10 reset enables", x_we, 0);

    // IDIVS (R1, R4, R7)
    run_op(2'b10, 16'd100, 16'd7, 16'h0, 0);
    run_op(2'b10, 16'hFF9C, 16'd7, 16'h0, 0);      // -100 / 7
    run_op(2'b10, 16'd100, 16'hFFF9, 16'h0, 0);    // 100 / -7
    run_op(2'b10, 16'h8000, 16'hFFFF, 16'h0, 0);   // -32768 / -1, overflow
    run_op(2'b11, 16'h8000, 16'h0001, 16'h0, 0);   // alt code, R1
    run_op(2'b10, 16'd3, 16'd9, 16'h0, 0);         // zero quotient
    // EDIV (R2, R7)
    run_op(2'b00, 16'hFFFF, 16'h0001, 16'hFFFF, 0);
    run_op(2'b00, 16'hFFFF, 16'hFFFF, 16'hFFFF, 0);
    run_op(2'b00, 16'h614E, 16'h1234, 16'h00BC, 0);
    run_op(2'b00, 16'h1234, 16'hFFFF, 16'h0000, 0);
    // EDIVS (R3, R4, R7)
    run_op(2'b01, 16'hFFF9, 16'd2, 16'hFFFF, 0);   // -7 / 2
    run_op(2'b01, 16'h0000, 16'hFFFF, 16'h8000, 0);// -2^31 / -1
    run_op(2'b01, 16'h0000, 16'h8000, 16'hC000, 0);
    run_op(2'b01, 16'h7FFF, 16'h0100, 16'h007F, 0);
    // zero divisors (R5)
    run_op(2'b10, 16'd55, 16'd0, 16'd1, 0);
    run_op(2'b00, 16'd55, 16'd0, 16'd1, 0);
    run_op(2'b01, 16'd55, 16'd0, 16'd1, 0);
    // restart attempt during a run (R9)
    run_op(2'b01, 16'h1357, 16'h0123, 16'hF00D, 1);
    run_op(2'b10, 16'd12345, 16'hFFFD, 16'h0, 1);
    // random operands
    for (int k = 0; k < 60; k++) begin
      logic [15:0] rd, rx, ry;
      rd = 16'($urandom);
      rx = (k % 7 == 0) ? 16'h0 : 16'($urandom >> (k % 16));
      ry = 16'($urandom >> (k % 17));
      run_op(2'(k % 4), rd, rx, ry, (k % 9) == 3);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule